// File: doc/BRIEF.md
# PCI Configuration Cycle Forwarding Decoder

This block sits in a two-port PCI-to-PCI bridge. It looks at the address phase of a configuration access and picks one of four outcomes. It can convert the access to Type 0 and drive an IDSEL line on the secondary bus. It can pass the access downstream unchanged as Type 1. It can pass a configuration write upstream unchanged as Type 1. Otherwise it ignores the access. The decision depends on the command, the access format bits, the target bus, device and function numbers, and the side of the bridge the access arrived on. The bridge's secondary and subordinate bus number registers are inputs to the decision.

The block samples a qualified address phase on a clock edge. One cycle later it presents the registered decision and the address to drive on the far side. On a Type 0 conversion it also gives a one-hot IDSEL vector, a master-abort flag for devices that have no IDSEL line, and a flag that limits the transfer to one data phase. Electrical signalling, the transaction queues and the data phases belong to other blocks.

Top module: `cfg_fwd_decoder`

## Requirements
- R1: An access counts as Type 1 only when `ad_in[1:0]` is 01b. Any other value gives decision 00 (ignore), whatever the other inputs are.
- R2: An access from the primary side takes decision 10 (downstream Type 1) when all of these hold: the command is configuration read (1010b) or configuration write (1011b), and `sec_bus < ad_in[23:16] <= sub_bus`. `ad_out` then equals `ad_in` unchanged.
- R3: An access from the secondary side takes decision 11 (upstream Type 1) when all of these hold: the command is 1011b, `ad_in[23:16]` lies outside the inclusive range `sec_bus..sub_bus`, `ad_in[15:11]` is 11111b and `ad_in[10:8]` is 111b. `ad_out` then equals `ad_in` unchanged. A read never goes upstream.
- R4: An access from the primary side with a configuration read or write command and `ad_in[23:16] == sec_bus` takes decision 01 (Type 0). In `ad_out`, bits [1:0] are 00b, bits [10:2] copy `ad_in[10:2]`, and bits [15:11] and [31:25] are zero.
- R5: On decision 01 with device number d in 0..8, bit d of `idsel` and bit 16+d of `ad_out` are the only IDSEL bits set.
- R6: On decision 01 with device number above 8, `idsel` and `ad_out[24:16]` are all zero, the decision stays 01, and `cfg_abort` is 1. In every other case `cfg_abort` is 0.
- R7: `single_beat` is 1 exactly when the decision is 01.
- R8: Every access not covered by R2 to R4 gives decision 00, with `ad_out`, `idsel`, `cfg_abort` and `single_beat` all zero.
- R9: The outputs show the address phase sampled on the edge where `addr_valid` was 1, starting one clock after that edge. If `addr_valid` was 0 at the edge, `dec_valid` is 0 and all outputs read as in R8.
- R10: While `rst_n` is low, `dec_valid`, `decision`, `ad_out`, `idsel`, `cfg_abort` and `single_beat` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_valid | input | 1 | Address phase of a configuration access is present |
| from_primary | input | 1 | 1: access arrived on the primary side; 0: on the secondary side |
| cmd | input | 4 | Bus command of the address phase |
| ad_in | input | 32 | Address word of the address phase |
| sec_bus | input | 8 | Secondary bus number register |
| sub_bus | input | 8 | Subordinate bus number register |
| dec_valid | output | 1 | Registered decision is valid |
| decision | output | 2 | 00 ignore, 01 Type 0, 10 downstream Type 1, 11 upstream Type 1 |
| ad_out | output | 32 | Address to drive on the far side |
| idsel | output | 9 | One-hot IDSEL for devices 0..8 |
| cfg_abort | output | 1 | Type 0 conversion with no IDSEL, ends in master abort |
| single_beat | output | 1 | Limit the transfer to one 32-bit data phase |

## Verification
The bench concentrates its stimulus on the bus-number boundaries. It drives a bus number equal to the secondary number, one above it, equal to the subordinate number, one above that, and one below the secondary number. A design that mixes up the exclusive and inclusive limits sends a Type 0 access downstream as Type 1, or sends an access for the bridge's own range upstream. Device numbers 8 and 9 sit on the edge of the IDSEL set. An off-by-one there either drops the device-8 line or drives AD[25] where a master abort is expected. Further cases are reads from the secondary side, device/function patterns that are all ones except for one bit, and format bits other than 01b. Each of these must be ignored, and a design that forwards any of them sends stray upstream cycles.

// File: rtl/cfgfwd_pkg.sv
// Package: shared decision encoding, command codes and address field
// positions for the configuration forwarding decoder.
package cfgfwd_pkg;

    // Forwarding outcome; the encoding is visible on the decision port.
    typedef enum logic [1:0] {
        FWD_IGNORE  = 2'b00,
        FWD_TYPE0   = 2'b01,
        FWD_DOWN_T1 = 2'b10,
        FWD_UP_T1   = 2'b11
    } fwd_kind_e;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;
    localparam logic [1:0] FMT_TYPE1  = 2'b01;

    // Field positions inside a Type 1 address word.
    localparam int BUS_LSB = 16;
    localparam int DEV_LSB = 11;
    localparam int FN_LSB  = 8;
    localparam int REG_LSB = 2;
    localparam int REG_MSB = 10;

endpackage

// File: rtl/cfgfwd_range_chk.sv
// Module: compares the target bus number against the bridge's secondary
// and subordinate registers.
// Assumes: plain unsigned numbers; a misprogrammed sub < sec simply makes
// the child window empty.
module cfgfwd_range_chk #(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W-1:0] bus_num,
    input  logic [BUS_W-1:0] sec_num,
    input  logic [BUS_W-1:0] sub_num,
    output logic             hit_sec,
    output logic             in_child,
    output logic             outside_span
);

    // Purpose: three comparisons that the forwarding rules need.
    always_comb begin
        hit_sec      = (bus_num == sec_num);
        in_child     = (bus_num > sec_num) && (bus_num <= sub_num);
        outside_span = (bus_num < sec_num) || (bus_num > sub_num);
    end

endmodule

// File: rtl/cfgfwd_idsel_gen.sv
// Module: turns a device number into a one-hot IDSEL vector for the
// devices that have a line of their own.
// Assumes: device numbers at or above NUM_IDSEL get no line.
module cfgfwd_idsel_gen #(
    parameter int DEV_W     = 5,
    parameter int NUM_IDSEL = 9
) (
    input  logic [DEV_W-1:0]     dev_num,
    output logic [NUM_IDSEL-1:0] idsel_vec,
    output logic                 no_line
);

    // One comparator for each device that has an IDSEL line.
    for (genvar g = 0; g < NUM_IDSEL; g++) begin : g_line
        assign idsel_vec[g] = (dev_num == DEV_W'(g));
    end

    // Purpose: flag a device number that no line covers.
    always_comb no_line = ~|idsel_vec;

endmodule

// File: rtl/cfgfwd_addr_xlate.sv
// Module: builds the Type 0 address word for the secondary side. It keeps
// the register field, places IDSEL above bit IDSEL_BASE and zeroes all the
// other bits.
// Assumes: IDSEL_BASE + NUM_IDSEL <= ADDR_W and IDSEL_BASE > REG_MSB.
module cfgfwd_addr_xlate
    import cfgfwd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_IDSEL  = 9,
    parameter int IDSEL_BASE = 16
) (
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic [NUM_IDSEL-1:0] idsel_vec,
    output logic [ADDR_W-1:0]    type0_addr
);

    // Purpose: place the fields of the converted address.
    always_comb begin
        type0_addr                          = '0;
        type0_addr[REG_MSB:REG_LSB]         = addr_in[REG_MSB:REG_LSB];
        type0_addr[IDSEL_BASE +: NUM_IDSEL] = idsel_vec;
    end

endmodule

// File: rtl/cfg_fwd_decoder.sv
// Module: top of the configuration forwarding decoder. It decodes one
// address phase and registers the outcome one clock later.
// Assumes: 32-bit address with bus in [23:16], device in [15:11] and
// function in [10:8]; rst_n is synchronous and active low.
module cfg_fwd_decoder
    import cfgfwd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BUS_W      = 8,
    parameter int NUM_IDSEL  = 9,
    parameter int IDSEL_BASE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 addr_valid,
    input  logic                 from_primary,
    input  logic [3:0]           cmd,
    input  logic [ADDR_W-1:0]    ad_in,
    input  logic [BUS_W-1:0]     sec_bus,
    input  logic [BUS_W-1:0]     sub_bus,
    output logic                 dec_valid,
    output logic [1:0]           decision,
    output logic [ADDR_W-1:0]    ad_out,
    output logic [NUM_IDSEL-1:0] idsel,
    output logic                 cfg_abort,
    output logic                 single_beat
);

    localparam int DEV_W = BUS_LSB - DEV_LSB;
    localparam int FN_W  = DEV_LSB - FN_LSB;

    logic [BUS_W-1:0]     f_bus;
    logic [DEV_W-1:0]     f_dev;
    logic [FN_W-1:0]      f_fn;
    logic                 is_type1, is_cfg_rw, is_cfg_wr, is_bcast_id;
    logic                 hit_sec, in_child, outside_span;
    logic [NUM_IDSEL-1:0] idsel_c;
    logic                 no_line;
    logic [ADDR_W-1:0]    type0_addr;

    fwd_kind_e            nxt_kind;
    logic [ADDR_W-1:0]    nxt_addr;
    logic [NUM_IDSEL-1:0] nxt_idsel;
    logic                 nxt_abort;

    // Purpose: split the address word into fields and qualify the command.
    always_comb begin
        f_bus       = ad_in[BUS_LSB +: BUS_W];
        f_dev       = ad_in[DEV_LSB +: DEV_W];
        f_fn        = ad_in[FN_LSB +: FN_W];
        is_type1    = (ad_in[1:0] == FMT_TYPE1);
        is_cfg_wr   = (cmd == CMD_CFG_WR);
        is_cfg_rw   = is_cfg_wr || (cmd == CMD_CFG_RD);
        is_bcast_id = (&f_dev) && (&f_fn);
    end

    cfgfwd_range_chk #(.BUS_W(BUS_W)) u_range (
        .bus_num      (f_bus),
        .sec_num      (sec_bus),
        .sub_num      (sub_bus),
        .hit_sec      (hit_sec),
        .in_child     (in_child),
        .outside_span (outside_span)
    );

    cfgfwd_idsel_gen #(.DEV_W(DEV_W), .NUM_IDSEL(NUM_IDSEL)) u_idsel (
        .dev_num   (f_dev),
        .idsel_vec (idsel_c),
        .no_line   (no_line)
    );

    cfgfwd_addr_xlate #(
        .ADDR_W     (ADDR_W),
        .NUM_IDSEL  (NUM_IDSEL),
        .IDSEL_BASE (IDSEL_BASE)
    ) u_xlate (
        .addr_in    (ad_in),
        .idsel_vec  (idsel_c),
        .type0_addr (type0_addr)
    );

    // Purpose: choose the outcome from direction, format, command and range.
    always_comb begin
        nxt_kind  = FWD_IGNORE;
        nxt_addr  = '0;
        nxt_idsel = '0;
        nxt_abort = 1'b0;
        if (is_type1) begin
            if (from_primary && is_cfg_rw) begin
                if (hit_sec) begin
                    nxt_kind  = FWD_TYPE0;
                    nxt_addr  = type0_addr;
                    nxt_idsel = idsel_c;
                    nxt_abort = no_line;
                end else if (in_child) begin
                    nxt_kind = FWD_DOWN_T1;
                    nxt_addr = ad_in;
                end
            end else if (!from_primary && is_cfg_wr && outside_span && is_bcast_id) begin
                nxt_kind = FWD_UP_T1;
                nxt_addr = ad_in;
            end
        end
    end

    // Purpose: register the decision one clock after the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid   <= 1'b0;
            decision    <= FWD_IGNORE;
            ad_out      <= '0;
            idsel       <= '0;
            cfg_abort   <= 1'b0;
            single_beat <= 1'b0;
        end else if (addr_valid) begin
            dec_valid   <= 1'b1;
            decision    <= nxt_kind;
            ad_out      <= nxt_addr;
            idsel       <= nxt_idsel;
            cfg_abort   <= nxt_abort;
            single_beat <= (nxt_kind == FWD_TYPE0);
        end else begin
            dec_valid   <= 1'b0;
            decision    <= FWD_IGNORE;
            ad_out      <= '0;
            idsel       <= '0;
            cfg_abort   <= 1'b0;
            single_beat <= 1'b0;
        end
    end

endmodule

// File: rtl/cfg_fwd_decoder_chk.sv
// Module: property checker for cfg_fwd_decoder, attached by bind.
// Assumes: the default 32-bit address layout.
module cfg_fwd_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        addr_valid,
    input logic        from_primary,
    input logic [3:0]  cmd,
    input logic [31:0] ad_in,
    input logic [7:0]  sec_bus,
    input logic [7:0]  sub_bus,
    input logic        dec_valid,
    input logic [1:0]  decision,
    input logic [31:0] ad_out,
    input logic [8:0]  idsel,
    input logic        cfg_abort,
    input logic        single_beat
);

    logic armed;

    // Purpose: enable the $past-based checks only after one clean cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (dec_valid == $past(addr_valid)));

    assert_fmt_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && decision != 2'b00) |-> ($past(ad_in[1:0]) == 2'b01));

    assert_up_qual_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && decision == 2'b11) |->
        (!$past(from_primary) && $past(cmd) == 4'b1011 &&
         $past(ad_in[15:8]) == 8'hFF && ad_out == $past(ad_in)));

    assert_down_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && decision == 2'b10) |->
        ($past(ad_in[23:16]) > $past(sec_bus) && $past(ad_in[23:16]) <= $past(sub_bus)));

    assert_idsel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(idsel));

    assert_abort_no_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_abort |-> (decision == 2'b01 && idsel == 9'd0));

    assert_single_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        single_beat |-> (decision == 2'b01));

    assert_type0_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (decision == 2'b01) |-> (ad_out[1:0] == 2'b00 && ad_out[31:25] == 7'd0));

endmodule

bind cfg_fwd_decoder cfg_fwd_decoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_valid   (addr_valid),
    .from_primary (from_primary),
    .cmd          (cmd),
    .ad_in        (ad_in),
    .sec_bus      (sec_bus),
    .sub_bus      (sub_bus),
    .dec_valid    (dec_valid),
    .decision     (decision),
    .ad_out       (ad_out),
    .idsel        (idsel),
    .cfg_abort    (cfg_abort),
    .single_beat  (single_beat)
);

// File: tb/sim_cfg_fwd_decoder.sv
// Bench: random address phases from a fixed seed plus directed corners,
// compared against a reference model written from the requirements.
module sim_cfg_fwd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid = 1'b0;
    logic        from_primary = 1'b0;
    logic [3:0]  cmd = 4'd0;
    logic [31:0] ad_in = 32'd0;
    logic [7:0]  sec_bus = 8'd0;
    logic [7:0]  sub_bus = 8'd0;
    logic        dec_valid;
    logic [1:0]  decision;
    logic [31:0] ad_out;
    logic [8:0]  idsel;
    logic        cfg_abort;
    logic        single_beat;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cfg_fwd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid),
        .from_primary(from_primary), .cmd(cmd), .ad_in(ad_in),
        .sec_bus(sec_bus), .sub_bus(sub_bus), .dec_valid(dec_valid),
        .decision(decision), .ad_out(ad_out), .idsel(idsel),
        .cfg_abort(cfg_abort), .single_beat(single_beat)
    );

    // Reference model of the forwarding rules.
    function automatic void model(input logic pri, input logic [3:0] c,
                                  input logic [31:0] a, input logic [7:0] s,
                                  input logic [7:0] u, output logic [1:0] d,
                                  output logic [31:0] oa, output logic [8:0] os,
                                  output logic ab);
        logic [7:0] b = a[23:16];
        int dev = int'(a[15:11]);
        d = 2'b00; oa = 32'd0; os = 9'd0; ab = 1'b0;
        if (a[1:0] != 2'b01) return;
        if (pri && (c == 4'b1010 || c == 4'b1011)) begin
            if (b == s) begin
                d = 2'b01;
                oa[10:2] = a[10:2];
                if (dev <= 8) begin os[dev] = 1'b1; oa[16+dev] = 1'b1; end
                else ab = 1'b1;
            end else if (b > s && b <= u) begin
                d = 2'b10; oa = a;
            end
        end else if (!pri && c == 4'b1011 && (b < s || b > u) &&
                     a[15:11] == 5'h1F && a[10:8] == 3'h7) begin
            d = 2'b11; oa = a;
        end
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one address phase and check the registered result.
    task automatic phase(input logic pri, input logic [3:0] c,
                         input logic [31:0] a, input logic [7:0] s,
                         input logic [7:0] u);
        logic [1:0] ed; logic [31:0] ea; logic [8:0] es; logic eb;
        string rq;
        model(pri, c, a, s, u, ed, ea, es, eb);
        @(negedge clk);
        addr_valid = 1'b1; from_primary = pri; cmd = c; ad_in = a;
        sec_bus = s; sub_bus = u;
        @(negedge clk);
        addr_valid = 1'b0;
        case (ed)
            2'b01:   rq = "R4";
            2'b10:   rq = "R2";
            2'b11:   rq = "R3";
            default: rq = (a[1:0] != 2'b01) ? "R1" : "R8";
        endcase
        cmp("R9", "dec_valid", 32'(dec_valid), 32'd1);
        cmp(rq, "decision", 32'(decision), 32'(ed));
        cmp(rq, "ad_out", ad_out, ea);
        cmp("R5", "idsel", 32'(idsel), 32'(es));
        cmp("R6", "cfg_abort", 32'(cfg_abort), 32'(eb));
        cmp("R7", "single_beat", 32'(single_beat), 32'(ed == 2'b01));
    endtask

    function automatic logic [31:0] mk(input logic [7:0] b, input logic [4:0] d,
                                       input logic [2:0] f, input logic [5:0] r,
                                       input logic [1:0] fmt);
        return {8'hA5, b, d, f, r, fmt};
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < 150000", cyc);
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R10: reset state
        cmp("R10", "dec_valid", 32'(dec_valid), 32'd0);
        cmp("R10", "decision", 32'(decision), 32'd0);
        cmp("R10", "ad_out", ad_out, 32'd0);
        cmp("R10", "idsel", 32'(idsel), 32'd0);
        rst_n = 1'b1;

        // Directed corners: secondary bus 10, subordinate bus 20
        phase(1, 4'b1010, mk(8'd10, 5'd0, 3'd2, 6'h3F, 2'b01), 8'd10, 8'd20); // R4 R5 dev0
        phase(1, 4'b1011, mk(8'd10, 5'd8, 3'd0, 6'h15, 2'b01), 8'd10, 8'd20); // R5 dev8 -> AD24
        phase(1, 4'b1011, mk(8'd10, 5'd9, 3'd0, 6'h15, 2'b01), 8'd10, 8'd20); // R6 dev9 abort
        phase(1, 4'b1010, mk(8'd10, 5'd31, 3'd7, 6'h01, 2'b01), 8'd10, 8'd20); // R6 dev31
        phase(1, 4'b1010, mk(8'd11, 5'd3, 3'd1, 6'h00, 2'b01), 8'd10, 8'd20); // R2 low edge
        phase(1, 4'b1011, mk(8'd20, 5'd3, 3'd1, 6'h00, 2'b01), 8'd10, 8'd20); // R2 high edge
        phase(1, 4'b1011, mk(8'd21, 5'd3, 3'd1, 6'h00, 2'b01), 8'd10, 8'd20); // R8 past sub
        phase(1, 4'b0110, mk(8'd10, 5'd1, 3'd1, 6'h00, 2'b01), 8'd10, 8'd20); // R8 memory read
        phase(1, 4'b1010, mk(8'd10, 5'd1, 3'd1, 6'h00, 2'b00), 8'd10, 8'd20); // R1 fmt 00
        phase(1, 4'b1010, mk(8'd15, 5'd1, 3'd1, 6'h00, 2'b11), 8'd10, 8'd20); // R1 fmt 11
        phase(0, 4'b1011, mk(8'd9, 5'd31, 3'd7, 6'h00, 2'b01), 8'd10, 8'd20); // R3 below sec
        phase(0, 4'b1011, mk(8'd21, 5'd31, 3'd7, 6'h00, 2'b01), 8'd10, 8'd20); // R3 above sub
        phase(0, 4'b1011, mk(8'd10, 5'd31, 3'd7, 6'h00, 2'b01), 8'd10, 8'd20); // R3 sec inclusive
        phase(0, 4'b1011, mk(8'd20, 5'd31, 3'd7, 6'h00, 2'b01), 8'd10, 8'd20); // R3 sub inclusive
        phase(0, 4'b1010, mk(8'd30, 5'd31, 3'd7, 6'h00, 2'b01), 8'd10, 8'd20); // R3 read
        phase(0, 4'b1011, mk(8'd30, 5'd30, 3'd7, 6'h00, 2'b01), 8'd10, 8'd20); // R3 dev bit
        phase(0, 4'b1011, mk(8'd30, 5'd31, 3'd6, 6'h00, 2'b01), 8'd10, 8'd20); // R3 fn bit

        // R9: an idle edge clears the outputs
        @(negedge clk);
        cmp("R9", "idle dec_valid", 32'(dec_valid), 32'd0);
        cmp("R9", "idle decision", 32'(decision), 32'd0);
        cmp("R9", "idle ad_out", ad_out, 32'd0);

        // Random phases biased toward the range boundaries
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] s, u, b;
            logic [4:0] d;
            logic [2:0] f;
            logic [3:0] c;
            logic [1:0] fmt;
            s = 8'($urandom_range(1, 200));
            u = s + 8'($urandom_range(0, 20));
            case ($urandom_range(0, 4))
                0: b = s;
                1: b = s + 8'd1;
                2: b = u;
                3: b = u + 8'd1;
                default: b = 8'($urandom);
            endcase
            d = ($urandom_range(0, 2) == 0) ? 5'h1F : 5'($urandom_range(0, 12));
            f = ($urandom_range(0, 1) == 0) ? 3'h7 : 3'($urandom);
            case ($urandom_range(0, 3))
                0: c = 4'b1010;
                1, 2: c = 4'b1011;
                default: c = 4'($urandom);
            endcase
            fmt = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b01;
            phase(1'($urandom), c, mk(b, d, f, 6'($urandom), fmt), s, u);
        end
        finish_up();
    end

endmodule